// File: doc/BRIEF.md
# Digital Potentiometer Wiper Register Controller

This block holds the position code of a resistor-ladder wiper and turns it into a registered one-hot tap-select vector. With the default 8-bit code there are 256 select lines and 255 segments between the low and the high terminal. Only one select line is ever active. The wiper can be changed in three ways: written directly from a byte-wide data bus, loaded from one of a small bank of data registers, or moved one position at a time by a step strobe with a direction flag. The wiper can also be copied into any bank register, and any bank register or the wiper itself can be read back onto the output bus.

A command is presented as a one-cycle strobe together with an opcode, a register index and a data byte, and it takes effect on that clock edge. Stepping is handled by a three-state position-zone machine. `ZONE_LOW` means the code is 0. `ZONE_MID` means the code lies strictly between the ends. `ZONE_HIGH` means the code is all ones. The zone blocks a down-step in `ZONE_LOW` and an up-step in `ZONE_HIGH`, which makes stepping saturate at both ends. The zone moves on every edge to the zone of the next wiper value. Its transitions are low-to-mid and high-to-mid (step away from an end, or a load), mid-to-low and mid-to-high (step or load onto an end), low-to-high and high-to-low (a load of the opposite end code), and stay.

Top module: `tap_wiper_ctrl`

## Requirements
- R1: After reset the wiper and every bank register hold 0, `tap_sel` has only bit 0 set, `data_out` is 0 and `rd_valid` is low.
- R2: `tap_sel` always has exactly one bit set. Bit k is set when the wiper code is k, so bit 0 is the low-terminal tap and bit 255 is the high-terminal tap.
- R3: `tap_sel` is registered and shows the wiper code from the previous cycle. It changes one cycle after the wiper changes.
- R4: Opcode 3'b000 writes `data_in` into bank register `cmd_idx`. Opcode 3'b001 reads that register to the output bus.
- R5: Opcode 3'b010 loads the wiper from bank register `cmd_idx`. Opcode 3'b011 saves the wiper into bank register `cmd_idx`.
- R6: Opcode 3'b100 writes `data_in` into the wiper. Opcode 3'b101 reads the wiper to the output bus.
- R7: A step strobe with `step_up`=1 adds 1 to the wiper, and a step strobe with `step_up`=0 subtracts 1.
- R8: Stepping saturates. An up-step at code 255 and a down-step at code 0 leave the wiper unchanged.
- R9: When `cmd_valid` and `step_en` are high in the same cycle, the command executes and the step is dropped, even if the command does not touch the wiper.
- R10: A read command loads `data_out` on its own edge and raises `rd_valid` for exactly one cycle. At all other times `data_out` holds its last value.
- R11: Opcodes 3'b110 and 3'b111 change no register and do not raise `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 3 | Command opcode |
| cmd_idx | input | 2 | Bank register index |
| data_in | input | 8 | Write data byte |
| data_out | output | 8 | Read data byte, held |
| rd_valid | output | 1 | Read data valid pulse |
| step_en | input | 1 | Step strobe, one cycle |
| step_up | input | 1 | Step direction, 1 = up |
| tap_sel | output | 256 | One-hot tap-select lines |

## Verification
The bench builds the block with its default parameters: an 8-bit code, 256 select lines and four bank registers. With that configuration, every wiper code can be swept through the direct-write path, checking both the select line and the readback for each one. A full walk from code 0 up through 255 and back down covers every increment and decrement, including the saturation at each end. The four-entry bank is small enough that every index is exercised for write, read, load and save, along with the collision of a command and a step and the two unused opcodes.

// File: rtl/tap_wiper_pkg.sv
package tap_wiper_pkg;

    typedef enum logic [2:0] {
        OP_REG_WRITE   = 3'b000,
        OP_REG_READ    = 3'b001,
        OP_WIPER_LOAD  = 3'b010,
        OP_WIPER_SAVE  = 3'b011,
        OP_WIPER_WRITE = 3'b100,
        OP_WIPER_READ  = 3'b101,
        OP_NOP_A       = 3'b110,
        OP_NOP_B       = 3'b111
    } cmd_op_e;

    typedef enum logic [1:0] {
        ZONE_LOW  = 2'd0,
        ZONE_MID  = 2'd1,
        ZONE_HIGH = 2'd2
    } zone_e;

endpackage

// File: rtl/wiper_bank_regs.sv
module wiper_bank_regs #(
    parameter int CODE_W   = 8,
    parameter int NUM_REGS = 4,
    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [CODE_W-1:0] wr_data,
    output logic [CODE_W-1:0] rd_data
);

    logic [CODE_W-1:0] regs_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[g] <= '0;
            end else if (wr_en && (idx == IDX_W'(g))) begin
                regs_q[g] <= wr_data;
            end
        end
    end

    assign rd_data = regs_q[idx];

endmodule

// File: rtl/wiper_zone_fsm.sv
module wiper_zone_fsm
    import tap_wiper_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [CODE_W-1:0] load_val,
    input  logic              step_en,
    input  logic              step_up,
    output logic [CODE_W-1:0] wiper_q,
    output zone_e             zone_q
);

    localparam logic [CODE_W-1:0] CODE_MAX = '1;

    zone_e             zone_d;
    logic [CODE_W-1:0] wiper_d;

    // next wiper: load has priority, step is gated by the current zone
    always_comb begin
        wiper_d = wiper_q;
        if (load_en) begin
            wiper_d = load_val;
        end else if (step_en) begin
            unique case (zone_q)
                ZONE_LOW:  if (step_up)  wiper_d = wiper_q + 1'b1;
                ZONE_HIGH: if (!step_up) wiper_d = wiper_q - 1'b1;
                ZONE_MID:  wiper_d = step_up ? wiper_q + 1'b1 : wiper_q - 1'b1;
                default:   wiper_d = wiper_q;
            endcase
        end
    end

    // next zone follows the next wiper value
    always_comb begin
        if (wiper_d == '0) begin
            zone_d = ZONE_LOW;
        end else if (wiper_d == CODE_MAX) begin
            zone_d = ZONE_HIGH;
        end else begin
            zone_d = ZONE_MID;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zone_q <= ZONE_LOW;
        end else begin
            zone_q <= zone_d;
        end
    end

    // wiper register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wiper_q <= '0;
        end else begin
            wiper_q <= wiper_d;
        end
    end

endmodule

// File: rtl/tap_onehot_decoder.sv
module tap_onehot_decoder #(
    parameter int CODE_W = 8,
    localparam int TAPS  = 1 << CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code,
    output logic [TAPS-1:0]   sel
);

    for (genvar t = 0; t < TAPS; t++) begin : g_tap
        if (t == 0) begin : g_low
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sel[t] <= 1'b1;
                else        sel[t] <= (code == CODE_W'(t));
            end
        end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sel[t] <= 1'b0;
                else        sel[t] <= (code == CODE_W'(t));
            end
        end
    end

endmodule

// File: rtl/tap_wiper_ctrl.sv
module tap_wiper_ctrl
    import tap_wiper_pkg::*;
#(
    parameter int CODE_W   = 8,
    parameter int NUM_REGS = 4,
    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int TAPS    = 1 << CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [IDX_W-1:0]  cmd_idx,
    input  logic [CODE_W-1:0] data_in,
    output logic [CODE_W-1:0] data_out,
    output logic              rd_valid,
    input  logic              step_en,
    input  logic              step_up,
    output logic [TAPS-1:0]   tap_sel
);

    cmd_op_e           op;
    logic              bank_we;
    logic [CODE_W-1:0] bank_wdata;
    logic [CODE_W-1:0] bank_rdata;
    logic              wiper_load;
    logic [CODE_W-1:0] wiper_load_val;
    logic              step_gated;
    logic              rd_fire;
    logic [CODE_W-1:0] rd_value;
    logic [CODE_W-1:0] wiper_code;
    zone_e             zone;

    assign op = cmd_op_e'(cmd_op);

    // command decode
    always_comb begin
        bank_we        = 1'b0;
        bank_wdata     = data_in;
        wiper_load     = 1'b0;
        wiper_load_val = data_in;
        rd_fire        = 1'b0;
        rd_value       = bank_rdata;
        if (cmd_valid) begin
            unique case (op)
                OP_REG_WRITE:   bank_we = 1'b1;
                OP_REG_READ:    rd_fire = 1'b1;
                OP_WIPER_LOAD: begin
                    wiper_load     = 1'b1;
                    wiper_load_val = bank_rdata;
                end
                OP_WIPER_SAVE: begin
                    bank_we    = 1'b1;
                    bank_wdata = wiper_code;
                end
                OP_WIPER_WRITE: wiper_load = 1'b1;
                OP_WIPER_READ: begin
                    rd_fire  = 1'b1;
                    rd_value = wiper_code;
                end
                OP_NOP_A, OP_NOP_B: ;
                default: ;
            endcase
        end
    end

    // a command in the same cycle drops the step
    assign step_gated = step_en && !cmd_valid;

    wiper_bank_regs #(
        .CODE_W   (CODE_W),
        .NUM_REGS (NUM_REGS)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bank_we),
        .idx     (cmd_idx),
        .wr_data (bank_wdata),
        .rd_data (bank_rdata)
    );

    wiper_zone_fsm #(
        .CODE_W (CODE_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (wiper_load),
        .load_val (wiper_load_val),
        .step_en  (step_gated),
        .step_up  (step_up),
        .wiper_q  (wiper_code),
        .zone_q   (zone)
    );

    tap_onehot_decoder #(
        .CODE_W (CODE_W)
    ) u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .code  (wiper_code),
        .sel   (tap_sel)
    );

    // read output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_out <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_fire;
            if (rd_fire) begin
                data_out <= rd_value;
            end
        end
    end

endmodule

// File: rtl/tap_wiper_checker.sv
module tap_wiper_checker #(
    parameter int CODE_W = 8,
    localparam int TAPS  = 1 << CODE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [2:0]        cmd_op,
    input logic              step_en,
    input logic              step_up,
    input logic [CODE_W-1:0] wiper_code,
    input logic [TAPS-1:0]   tap_sel,
    input logic              rd_valid
);

    localparam logic [CODE_W-1:0] CODE_MAX = '1;

    a_r2_single_tap: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tap_sel) == 1);

    a_r3_tap_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> tap_sel[$past(wiper_code)]);

    a_r7_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && step_up && !cmd_valid && wiper_code != CODE_MAX)
        |=> wiper_code == $past(wiper_code) + 1'b1);

    a_r7_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !step_up && !cmd_valid && wiper_code != '0)
        |=> wiper_code == $past(wiper_code) - 1'b1);

    a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !cmd_valid &&
         ((step_up && wiper_code == CODE_MAX) || (!step_up && wiper_code == '0)))
        |=> $stable(wiper_code));

    a_r9_cmd_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && cmd_valid && (cmd_op == 3'b000 || cmd_op == 3'b001 ||
                                  cmd_op == 3'b011 || cmd_op == 3'b101))
        |=> $stable(wiper_code));

    a_r10_read_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == 3'b001 || cmd_op == 3'b101)) |=> rd_valid);

    a_r11_nop_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op[2:1] == 2'b11 && !step_en)
        |=> (!rd_valid && $stable(wiper_code)));

endmodule

bind tap_wiper_ctrl tap_wiper_checker #(
    .CODE_W (CODE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .step_en    (step_en),
    .step_up    (step_up),
    .wiper_code (wiper_code),
    .tap_sel    (tap_sel),
    .rd_valid   (rd_valid)
);

// File: tb/sim_tap_wiper_ctrl.sv
`timescale 1ns/1ps
module sim_tap_wiper_ctrl;

    localparam int CW   = 8;
    localparam int NR   = 4;
    localparam int TAPS = 1 << CW;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cmd_valid = 1'b0;
    logic [2:0]      cmd_op = '0;
    logic [1:0]      cmd_idx = '0;
    logic [CW-1:0]   data_in = '0;
    logic [CW-1:0]   data_out;
    logic            rd_valid;
    logic            step_en = 1'b0;
    logic            step_up = 1'b0;
    logic [TAPS-1:0] tap_sel;

    int n_checks = 0;
    int n_fail   = 0;
    int exp_w    = 0;
    int exp_bank [NR];

    always #2.5 clk = ~clk;

    tap_wiper_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_idx(cmd_idx), .data_in(data_in), .data_out(data_out),
        .rd_valid(rd_valid), .step_en(step_en), .step_up(step_up),
        .tap_sel(tap_sel)
    );

    task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one command, optional simultaneous step; returns at the following negedge
    task automatic cmd(input logic [2:0] op, input int idx, input int d,
                       input logic stp = 1'b0, input logic up = 1'b0);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_idx = 2'(idx); data_in = CW'(d);
        step_en = stp; step_up = up;
        @(negedge clk);
        cmd_valid = 1'b0; step_en = 1'b0;
    endtask

    task automatic step(input logic up);
        @(negedge clk);
        step_en = 1'b1; step_up = up;
        @(negedge clk);
        step_en = 1'b0;
    endtask

    task automatic read_wiper(input string req, input int exp);
        cmd(3'b101, 0, 0);
        chk(req, 256'(rd_valid), 256'(1));
        chk(req, 256'(data_out), 256'(exp));
    endtask

    task automatic check_tap(input string req, input int code);
        chk(req, tap_sel, 256'(1) << code);
    endtask

    initial begin
        #(5.0 * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < NR; i++) exp_bank[i] = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check_tap("R1", 0);
        chk("R1", 256'(data_out), 256'(0));
        chk("R1", 256'(rd_valid), 256'(0));
        rst_n = 1'b1;
        for (int i = 0; i < NR; i++) begin
            cmd(3'b001, i, 0);
            chk("R1", 256'(data_out), 256'(0));
        end
        read_wiper("R1", 0);

        // R6/R2/R3: sweep every code through direct write
        for (int c = 0; c < TAPS; c++) begin
            cmd(3'b100, 0, c);
            // R3: tap still shows the old code in the cycle after the write
            if (c > 0) check_tap("R3", c - 1);
            @(negedge clk);
            check_tap("R2", c);
            read_wiper("R6", c);
            chk("R10", 256'(rd_valid), 256'(1));
            @(negedge clk);
            chk("R10", 256'(rd_valid), 256'(0));
            chk("R10", 256'(data_out), 256'(c));
        end

        // R8 saturation at the top, R7 walk down, R8 at the bottom
        exp_w = 255;
        step(1'b1);
        read_wiper("R8", 255);
        for (int k = 0; k < 256; k++) begin
            step(1'b0);
            if (exp_w > 0) exp_w--;
            @(negedge clk);
            check_tap("R7", exp_w);
        end
        read_wiper("R8", 0);
        for (int k = 0; k < 256; k++) begin
            step(1'b1);
            if (exp_w < 255) exp_w++;
            @(negedge clk);
            check_tap("R7", exp_w);
        end
        read_wiper("R8", 255);

        // R4 bank write/read
        for (int i = 0; i < NR; i++) begin
            exp_bank[i] = 8'h3C ^ (i * 37);
            cmd(3'b000, i, exp_bank[i]);
        end
        for (int i = NR - 1; i >= 0; i--) begin
            cmd(3'b001, i, 0);
            chk("R4", 256'(data_out), 256'(exp_bank[i]));
        end

        // R5 load wiper from each register, then save to neighbour
        for (int i = 0; i < NR; i++) begin
            cmd(3'b010, i, 8'hEE);
            read_wiper("R5", exp_bank[i]);
            @(negedge clk);
            check_tap("R5", exp_bank[i]);
        end
        exp_w = exp_bank[NR-1];
        cmd(3'b011, 1, 0);
        exp_bank[1] = exp_w;
        cmd(3'b001, 1, 0);
        chk("R5", 256'(data_out), 256'(exp_w));

        // R9 command with step in same cycle: step dropped
        cmd(3'b000, 2, 8'h55, 1'b1, 1'b1);
        exp_bank[2] = 8'h55;
        read_wiper("R9", exp_w);
        cmd(3'b100, 0, 8'h80, 1'b1, 1'b0);
        read_wiper("R9", 8'h80);
        exp_w = 8'h80;
        cmd(3'b001, 2, 0);
        chk("R9", 256'(data_out), 256'(8'h55));

        // R11 unused opcodes
        cmd(3'b001, 3, 0);
        cmd(3'b110, 3, 8'h11);
        chk("R11", 256'(rd_valid), 256'(0));
        chk("R11", 256'(data_out), 256'(exp_bank[3]));
        cmd(3'b111, 0, 8'h22);
        chk("R11", 256'(rd_valid), 256'(0));
        read_wiper("R11", exp_w);
        for (int i = 0; i < NR; i++) begin
            cmd(3'b001, i, 0);
            chk("R11", 256'(data_out), 256'(exp_bank[i]));
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule